// File: doc/BRIEF.md
# Iterative Logical Right Shifter

This block shifts a data word right by a variable amount without a barrel shifter. A start strobe captures a data operand and a shift amount. The amount goes into a separate down-counter. A small sequencer then loops through three steps per bit position. First it moves the data one place right, filling the top bit with zero. Then it decrements the counter. Then it tests the counter for zero. When the counter reads zero, the operation ends. The block drops busy and issues a one-cycle done pulse, and the final word appears on the result output.

Latency therefore grows linearly with the shift amount. Only a one-bit shift path and a decrementer are needed, whatever the data width. The block suits a controller that can tolerate variable timing. It accepts a new operation in any cycle where busy is low, including the cycle that carries the done pulse of the previous operation.

Top module: `iter_rshift`

## Requirements
- R1: After reset, busy is 0, done is 0 and result is all zeros.
- R2: When start is 1 while busy is 0, the operands are captured on that clock edge, and busy reads 1 from the next cycle on.
- R3: The final result equals data_in shifted right logically by amount_in, with zeros entering at the most significant bit.
- R4: Done is asserted exactly 3*amount_in + 1 clock cycles after the edge that captured start, so each bit position costs three cycles (shift, decrement, test).
- R5: A shift amount of 0 gives done one cycle after the capture edge, with result equal to the unchanged data operand.
- R6: A shift amount equal to or greater than DATA_W gives an all-zero result. Done is still asserted at 3*amount_in + 1 cycles.
- R7: A start strobe while busy is 1 has no effect: the running operation keeps its result and its latency.
- R8: Done is a single-cycle pulse. Busy is 0 whenever done is 1.
- R9: While busy is 0 and start is 0, result holds its value.
- R10: A start in the same cycle as a done pulse is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin an operation when idle |
| data_in | input | DATA_W | Word to be shifted |
| amount_in | input | AMT_W | Shift amount, unsigned |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is final |
| result | output | DATA_W | Shifted word; holds its value while idle |

## Verification
Two events can land in the same cycle: the done pulse that ends one operation and the start strobe that begins the next. The bench creates this overlap by raising start in the very cycle where it sees done. It then checks three things: busy rises on the next cycle, the new operation's latency and value are exact, and the old done does not linger. A second overlap is also exercised: a start strobe that arrives mid-operation, including the final test cycle, must be dropped. The bench judges this by the running operation's unchanged result and latency.

// File: rtl/iter_rshift_pkg.sv
package iter_rshift_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TEST  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DEC   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/iter_rshift_rst_sync.sv
module iter_rshift_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/iter_rshift_counter.sv
module iter_rshift_counter #(
  parameter int AMT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             dec_en,
  input  logic [AMT_W-1:0] amount,
  output logic             is_zero
);
  logic [AMT_W-1:0] cnt_q;
  logic [AMT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_en)     cnt_d = amount;
    else if (dec_en) cnt_d = cnt_q - AMT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_en || dec_en) cnt_q <= cnt_d;
  end

  assign is_zero = (cnt_q == '0);

  // R4: the counter never steps below zero
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> cnt_q != '0);

  // R4: one decrement removes exactly one from the remaining count
  p_dec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !load_en) |=> cnt_q == AMT_W'($past(cnt_q) - AMT_W'(1)));
endmodule

// File: rtl/iter_rshift_datapath.sv
module iter_rshift_datapath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (load_en)       word_d = din;
    else if (shift_en) word_d = {1'b0, word_q[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  word_q <= '0;
    else if (load_en || shift_en) word_q <= word_d;
  end

  assign dout = word_q;

  // R3: a shift step leaves a zero in the top bit
  p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> word_q[DATA_W-1] == 1'b0);

  // R2: a capture places the operand in the working register
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> word_q == $past(din));
endmodule

// File: rtl/iter_rshift_seq.sv
module iter_rshift_seq
  import iter_rshift_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cnt_zero,
  output logic load_en,
  output logic shift_en,
  output logic dec_en,
  output logic busy,
  output logic done
);
  seq_state_t state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d  = state_q;
    done_d   = 1'b0;
    load_en  = 1'b0;
    shift_en = 1'b0;
    dec_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          state_d = ST_TEST;
        end
      end
      ST_TEST: begin
        if (cnt_zero) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        shift_en = 1'b1;
        state_d  = ST_DEC;
      end
      ST_DEC: begin
        dec_en  = 1'b1;
        state_d = ST_TEST;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: done only while idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> state_q == ST_IDLE);

  // R7: a strobe during an operation never triggers a capture
  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !load_en);

  // R4: a shift step is always followed by a decrement step
  p_shift_then_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> dec_en);
endmodule

// File: rtl/iter_rshift.sv
module iter_rshift #(
  parameter int DATA_W = 8,
  parameter int AMT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data_in,
  input  logic [AMT_W-1:0]  amount_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  logic rst_n_int;
  logic load_en, shift_en, dec_en, cnt_zero;

  iter_rshift_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  iter_rshift_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start    (start),
    .cnt_zero (cnt_zero),
    .load_en  (load_en),
    .shift_en (shift_en),
    .dec_en   (dec_en),
    .busy     (busy),
    .done     (done)
  );

  iter_rshift_counter #(.AMT_W(AMT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load_en (load_en),
    .dec_en  (dec_en),
    .amount  (amount_in),
    .is_zero (cnt_zero)
  );

  iter_rshift_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load_en  (load_en),
    .shift_en (shift_en),
    .din      (data_in),
    .dout     (result)
  );

  // R9: idle without start keeps the result
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!busy && !start) |=> $stable(result));

  // R2: an idle start makes the block busy next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!busy && start) |=> busy);
endmodule

// File: tb/iter_rshift_test.sv
`timescale 1ns/1ps
module iter_rshift_test;
  localparam int DATA_W = 8;
  localparam int AMT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [DATA_W-1:0] data_in;
  logic [AMT_W-1:0]  amount_in;
  logic              busy, done;
  logic [DATA_W-1:0] result;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  iter_rshift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
    .amount_in(amount_in), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [DATA_W-1:0] ref_shift(input logic [DATA_W-1:0] d,
                                                  input int unsigned n);
    logic [DATA_W-1:0] v = d;
    for (int unsigned i = 0; i < n; i++) v = v / 2;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge with the block idle (or at a done cycle).
  // Returns at the negedge where done is seen.
  task automatic run_op(input logic [DATA_W-1:0] d, input logic [AMT_W-1:0] n,
                        input int poke_at, input string req);
    int lat;
    logic [DATA_W-1:0] exp;
    exp = ref_shift(d, n);
    start = 1'b1; data_in = d; amount_in = n;
    @(negedge clk);
    start = 1'b0; data_in = ~d; amount_in = n + 8'd1;
    check(busy === 1'b1, "R2", "busy after start", busy, 1);
    check(done === 1'b0, "R8", "done cleared", done, 0);
    lat = 0;
    while (1) begin
      if (lat == poke_at) start = 1'b1;   // R7 strobe while busy
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
      if (done === 1'b1 || lat > 2000) break;
    end
    check(lat == 3 * int'(n) + 1, req, "latency", lat, 3 * int'(n) + 1);
    check(result === exp, req, "result", result, exp);
    check(busy === 1'b0, "R8", "busy with done", busy, 0);
  endtask

  task automatic idle_gap(input int k);
    logic [DATA_W-1:0] held;
    held = result;
    repeat (k) @(negedge clk);
    check(result === held, "R9", "result held", result, held);
    check(done === 1'b0, "R8", "done single pulse", done, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; data_in = '0; amount_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(busy === 1'b0, "R1", "busy at reset", busy, 0);
    check(done === 1'b0, "R1", "done at reset", done, 0);
    check(result === '0, "R1", "result at reset", result, 0);

    // R3 example pattern
    run_op(8'b0000_1101, 8'd3, -1, "R3");
    idle_gap(2);
    // R5 zero amount
    run_op(8'hA7, 8'd0, -1, "R5");
    idle_gap(3);
    // R6 amount at and beyond width
    run_op(8'hFF, 8'd8, -1, "R6");
    idle_gap(1);
    run_op(8'h80, 8'd7, -1, "R3");
    idle_gap(1);
    run_op(8'hC3, 8'd13, -1, "R6");
    idle_gap(1);
    run_op(8'h5A, 8'd255, -1, "R6");
    idle_gap(2);
    // R7 strobes mid-operation and in the final test cycle
    run_op(8'hF0, 8'd2, 2, "R7");
    idle_gap(1);
    run_op(8'h9C, 8'd3, 9, "R7");
    idle_gap(1);
    // R10 back-to-back: start in the done cycle
    run_op(8'hE1, 8'd1, -1, "R4");
    run_op(8'h3E, 8'd2, -1, "R10");
    run_op(8'h77, 8'd0, -1, "R10");
    run_op(8'hB4, 8'd5, -1, "R10");
    idle_gap(1);

    // random mix, R3/R4
    for (int i = 0; i < 60; i++) begin
      logic [DATA_W-1:0] d;
      logic [AMT_W-1:0]  n;
      int gap;
      d = DATA_W'($urandom);
      n = ($urandom_range(0, 9) == 0) ? AMT_W'($urandom_range(8, 40))
                                      : AMT_W'($urandom_range(0, 7));
      run_op(d, n, ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 3 * int'(n))) : -1,
             "R4");
      gap = $urandom_range(0, 3);
      if (gap > 0) idle_gap(gap);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule